// File: doc/BRIEF.md
# Configurable XOR-Window Branch Direction Predictor

This block predicts whether a conditional branch will be taken. It keeps one table of 2^n saturating counters, viewed as 2^(n-m) rows by 2^m columns, and an m-bit global record of recent branch outcomes. The low program-counter bits select the row. The column is the outcome record XORed with an m-bit slice of the program counter. The slice starts at a bit position set at runtime.

By moving that slice and by switching the outcome record out of the index, one table can act as any of five predictors: a plain PC-indexed predictor, a global two-level predictor, a hybrid of the two, the classic shared-index XOR predictor, or an extended form that XORs the history with higher address bits. The extended form separates branches that alias onto the same row.

The block has two ports. The predict port takes a PC and returns the direction at once. The update port takes a resolved branch PC and its outcome. It trains the selected counter and shifts the outcome into the history.

Top module: `xorwin_predictor`

## Requirements
- R1: After reset the history is all zeros. Every counter holds the weakly-not-taken value (binary 01 for 2-bit counters, 0 for 1-bit counters), so every PC is predicted not-taken (`pred_taken` = 0).
- R2: The entry index is `col * 2^(n-m) + row`, where `row` = PC bits 0..n-m-1 and `col` = history XOR PC bits `win_pos`..`win_pos`+m-1. The prediction is the MSB of the selected counter, and 1 means taken.
- R3: With `win_pos` = n-m and `hist_off` = 1, the table is addressed by PC bits 0..n-1 exactly, as a one-level predictor. PCs that differ only in bits n and above share an entry.
- R4: When `hist_off` = 1, the history term in both the predict and the update index is zero. The history register still records outcomes.
- R5: Each 2-bit counter counts up on taken and down on not-taken, saturating at 3 and 0.
- R6: On each update the outcome (1 = taken) shifts into history bit 0 and the older bits move up one place. Without an update the history holds.
- R7: For any `win_pos` with 0 <= `win_pos` <= n-2m and live history, the predictions match a plain two-level predictor whose index is `history * 2^(n-m) + row`.
- R8: A predict and an update in the same cycle: the prediction reflects the table before that update. The update index uses the history held before that update.
- R9: Window bits that fall at PC positions at or above the PC width read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| win_pos | input | WS_W | Lowest PC bit of the XOR window |
| hist_off | input | 1 | 1 forces the history term of the index to zero |
| pred_pc | input | PC_W | PC of the branch to predict |
| pred_taken | output | 1 | Predicted direction, 1 = taken |
| upd_valid | input | 1 | A resolved branch is presented this cycle |
| upd_pc | input | PC_W | PC of the resolved branch |
| upd_taken | input | 1 | Actual outcome, 1 = taken |

## Verification
The checker watches several properties on every cycle:
- The history holds without an update and shifts in the outcome with one (R6).
- The prediction holds while its inputs and the table hold (R8).
- Back-to-back updates to one entry move its counter by one step or hold it at a rail (R5).

The bench scenarios cover the rest:
- Index arithmetic across every window position, with history both on and off (R2, R4, R9).
- One-level aliasing and the reset state (R1, R3).
- The prediction is the same as a separate two-level model for low windows (R7).
- The same-cycle ordering of a predict and an update (R8).

// File: rtl/xorwin_predictor.sv
module xorwin_predictor #(
  parameter int IDX_W  = 10,
  parameter int HIST_W = 3,
  parameter int PC_W   = 16,
  parameter int CTR_W  = 2,
  parameter int WS_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WS_W-1:0]   win_pos,
  input  logic              hist_off,
  input  logic [PC_W-1:0]   pred_pc,
  output logic              pred_taken,
  input  logic              upd_valid,
  input  logic [PC_W-1:0]   upd_pc,
  input  logic              upd_taken
);
  localparam int ROW_W   = IDX_W - HIST_W;
  localparam int ENTRIES = 1 << IDX_W;
  localparam logic [CTR_W-1:0] CTR_MAX  = CTR_W'((1 << CTR_W) - 1);
  localparam logic [CTR_W-1:0] CTR_INIT = CTR_W'((1 << (CTR_W - 1)) - 1);

  logic [CTR_W-1:0]  tbl [ENTRIES];
  logic [HIST_W-1:0] hist;
  logic [HIST_W-1:0] hist_eff;
  logic [IDX_W-1:0]  pidx, uidx;
  logic [CTR_W-1:0]  uctr, nctr;

  function automatic logic [IDX_W-1:0] make_idx(
    input logic [PC_W-1:0] pc, input logic [WS_W-1:0] ws, input logic [HIST_W-1:0] h);
    logic [PC_W-1:0] sh;
    sh = pc >> ws;
    return {h ^ sh[HIST_W-1:0], pc[ROW_W-1:0]};
  endfunction

  assign hist_eff   = hist_off ? '0 : hist;
  assign pidx       = make_idx(pred_pc, win_pos, hist_eff);
  assign uidx       = make_idx(upd_pc, win_pos, hist_eff);
  assign pred_taken = tbl[pidx][CTR_W-1];
  assign uctr       = tbl[uidx];

  always_comb begin
    nctr = uctr;
    if (upd_taken) begin
      if (uctr != CTR_MAX) nctr = uctr + 1'b1;
    end else begin
      if (uctr != '0) nctr = uctr - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hist <= '0;
      for (int i = 0; i < ENTRIES; i++) tbl[i] <= CTR_INIT;
    end else if (upd_valid) begin
      hist      <= {hist[HIST_W-2:0], upd_taken};
      tbl[uidx] <= nctr;
    end
  end
endmodule

module xorwin_predictor_chk #(
  parameter int IDX_W  = 10,
  parameter int HIST_W = 3,
  parameter int PC_W   = 16,
  parameter int CTR_W  = 2,
  parameter int WS_W   = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [WS_W-1:0]   win_pos,
  input logic              hist_off,
  input logic [PC_W-1:0]   pred_pc,
  input logic              pred_taken,
  input logic              upd_valid,
  input logic              upd_taken,
  input logic [HIST_W-1:0] hist,
  input logic [IDX_W-1:0]  uidx,
  input logic [CTR_W-1:0]  uctr
);
  localparam logic [CTR_W-1:0] CMAX = CTR_W'((1 << CTR_W) - 1);

  a_r6_hist_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_valid |=> $stable(hist));

  a_r6_hist_shift: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid |=> (hist[0] == $past(upd_taken)) && (hist[HIST_W-1:1] == $past(hist[HIST_W-2:0])));

  a_r8_pred_steady: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!upd_valid) && $stable(pred_pc) && $stable(win_pos) && $stable(hist_off)) |-> $stable(pred_taken));

  a_r5_step_up: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(upd_valid) && upd_valid && uidx == $past(uidx) && $past(upd_taken))
      |-> ((uctr - $past(uctr)) == CTR_W'(1)) || (uctr == CMAX && $past(uctr) == CMAX));

  a_r5_step_down: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(upd_valid) && upd_valid && uidx == $past(uidx) && !$past(upd_taken))
      |-> (($past(uctr) - uctr) == CTR_W'(1)) || (uctr == '0 && $past(uctr) == '0));
endmodule

bind xorwin_predictor xorwin_predictor_chk #(
  .IDX_W(IDX_W), .HIST_W(HIST_W), .PC_W(PC_W), .CTR_W(CTR_W), .WS_W(WS_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .win_pos(win_pos), .hist_off(hist_off),
  .pred_pc(pred_pc), .pred_taken(pred_taken), .upd_valid(upd_valid),
  .upd_taken(upd_taken), .hist(hist), .uidx(uidx), .uctr(uctr)
);

// File: tb/tb_xorwin_predictor.sv
`timescale 1ns/1ps
module tb_xorwin_predictor;
  localparam int N = 10, M = 3, PW = 16, CW = 2, WW = 4;
  localparam int ROWS = 1 << (N - M), ENT = 1 << N;

  logic clk = 1'b0, rst_n;
  logic [WW-1:0] win_pos;
  logic hist_off, pred_taken, upd_valid, upd_taken;
  logic [PW-1:0] pred_pc, upd_pc;

  xorwin_predictor #(.IDX_W(N), .HIST_W(M), .PC_W(PW), .CTR_W(CW), .WS_W(WW)) dut (
    .clk(clk), .rst_n(rst_n), .win_pos(win_pos), .hist_off(hist_off),
    .pred_pc(pred_pc), .pred_taken(pred_taken), .upd_valid(upd_valid),
    .upd_pc(upd_pc), .upd_taken(upd_taken));

  always #2.5 clk = ~clk;

  int tests = 0, fails = 0;
  int mtab [ENT];
  int ttab [ENT];
  int mhist;
  int unsigned seed = 32'h1234_5678;

  function automatic int midx(int pc, int ws, int h);
    return ((h ^ ((pc >> ws) % (1 << M))) * ROWS) + (pc % ROWS);
  endfunction

  function automatic int sat(int v, bit up);
    if (up) return (v == 3) ? 3 : v + 1;
    return (v == 0) ? 0 : v - 1;
  endfunction

  task automatic check(bit got, bit exp, string tag);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%0d exp=%0d", tag, got, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; upd_valid = 1'b0; upd_taken = 1'b0;
    pred_pc = '0; upd_pc = '0; win_pos = 4'd7; hist_off = 1'b1;
    for (int i = 0; i < ENT; i++) begin mtab[i] = 1; ttab[i] = 1; end
    mhist = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
  endtask

  // called at a negedge; returns at the next negedge
  task automatic step(int ppc, int upc, bit uv, bit ut, bit two_lvl, string tag);
    int h;
    pred_pc = PW'(ppc); upd_pc = PW'(upc); upd_valid = uv; upd_taken = ut;
    h = hist_off ? 0 : mhist;
    #1;
    check(pred_taken, mtab[midx(ppc, int'(win_pos), h)] >= 2, tag);
    if (two_lvl) check(pred_taken, ttab[mhist * ROWS + ppc % ROWS] >= 2, "R7 two-level match");
    if (uv) begin
      mtab[midx(upc, int'(win_pos), h)] = sat(mtab[midx(upc, int'(win_pos), h)], ut);
      ttab[mhist * ROWS + upc % ROWS] = sat(ttab[mhist * ROWS + upc % ROWS], ut);
      mhist = ((mhist << 1) | int'(ut)) % (1 << M);
    end
    @(negedge clk);
    upd_valid = 1'b0;
  endtask

  task automatic peek(int pc, bit exp, string tag);
    pred_pc = PW'(pc);
    #1;
    check(pred_taken, exp, tag);
    @(negedge clk);
  endtask

  function automatic int unsigned rnd();
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 17);
    seed = seed ^ (seed << 5);
    return seed;
  endfunction

  initial begin : watchdog
    #(5ns * 190000);
    fails++;
    $display("FAIL watchdog got=hung exp=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    do_reset();
    // R1: every entry reads not-taken after reset
    for (int pc = 0; pc < ENT; pc++) peek(pc, 1'b0, "R1 reset not-taken");

    // R3: one-level mode, aliasing above bit n, column bit separates
    win_pos = 4'(N - M); hist_off = 1'b1;
    step(16'h05A, 16'h05A, 1, 1, 0, "R3 train");
    peek(16'h05A, 1'b1, "R3 trained pc");
    peek(16'h05A | 16'h0400, 1'b1, "R3 alias above n");
    peek(16'h05A ^ 16'h0200, 1'b0, "R3 column bit distinct");

    // R5: saturation of the 2-bit counter
    for (int k = 0; k < 5; k++) step(16'h033, 16'h033, 1, 1, 0, "R5 up");
    step(16'h033, 16'h033, 1, 0, 0, "R5 down once");
    peek(16'h033, 1'b1, "R5 3->2 still taken");
    step(16'h033, 16'h033, 1, 0, 0, "R5 down twice");
    peek(16'h033, 1'b0, "R5 2->1 not-taken");
    for (int k = 0; k < 4; k++) step(16'h033, 16'h033, 1, 0, 0, "R5 floor");
    step(16'h033, 16'h033, 1, 1, 0, "R5 from floor");
    peek(16'h033, 1'b0, "R5 0->1 not-taken");

    // R8: same-cycle predict and update see the old counter
    do_reset();
    pred_pc = 16'h044; upd_pc = 16'h044; upd_valid = 1'b1; upd_taken = 1'b1;
    #1; check(pred_taken, 1'b0, "R8 pre-update view");
    mtab[16'h044] = 2; ttab[16'h044] = 2; mhist = 1;
    @(negedge clk); upd_valid = 1'b0;
    peek(16'h044, 1'b1, "R8 post-update view");

    // R6 with R4: history recorded while disabled, used once enabled
    do_reset();
    win_pos = 4'd0;
    step(16'h010, 16'h010, 1, 1, 0, "R6 shift one");
    hist_off = 1'b0;
    // live history = 001 ; window pc[2:0] of 0x011 = 001 -> col 0, row 0x11
    step(16'h011, 16'h011, 1, 1, 0, "R4 live history index");
    hist_off = 1'b1;
    peek(16'h011, 1'b0, "R4 off: col=1 entry untouched");
    peek(16'h011 & 16'h07F | 16'h000, 1'b0, "R6 history term off");

    // R2 R4 R9: sweep all window positions, history on and off
    do_reset();
    for (int ws = 0; ws < 16; ws++) begin
      for (int off = 0; off < 2; off++) begin
        win_pos = 4'(ws); hist_off = off[0];
        for (int k = 0; k < 300; k++) begin
          int unsigned r;
          int pa, pb;
          r  = rnd();
          pa = int'((r[3:0] * 32'h1357 + (r[7:6] << 14)) & 32'hFFFF);
          pb = int'((r[11:8] * 32'h1357 + (r[13:12] << 14)) & 32'hFFFF);
          step(pa, pb, r[16], r[20] | r[21], 0, ws > 12 ? "R9 high window" : "R2 index");
        end
      end
    end

    // R7: low window equals a plain two-level predictor
    do_reset();
    win_pos = 4'd2; hist_off = 1'b0;
    for (int k = 0; k < 3000; k++) begin
      int unsigned r;
      int pa;
      r  = rnd();
      pa = int'((r[4:0] * 32'h0B3D) & 32'hFFFF);
      step(pa, pa, 1, r[9] | (r[4:0] < 5'd10), 1, "R7 low window");
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule